// File: doc/BRIEF.md
# Multi-Lane Serial Receive Packer

This block takes audio-style serial data arriving on several parallel lanes that share one bit clock and one frame sync. Every lane has its own shift register. All lanes use the same slot width, so all of them finish a sample on the same bit clock edge. At that point the block copies the finished words into holding registers, and a sequencer writes them into one shared receive FIFO. The sequencer writes one word per system clock, in ascending lane order, and skips lanes that are switched off. A burst-oriented consumer such as a DMA engine drains the FIFO through a valid/ready port, and can read the current fill level.

The bit clock, frame sync and lane data are inputs that are already synchronous to the system clock `clk_i`. The block detects a bit clock rising edge as a low-to-high change seen between two system clock edges. The bit clock has to stay low for at least two system clocks and high for at least two system clocks. The slot width must be at least half the lane count, so the sequencer always finishes before the next set of words arrives.

Top module: `mlane_rx_packer`

## Requirements
- R1: Each lane captures `sdata_i` on every bit clock rising edge, MSB first. A slot starts at the edge where `fsync_i` is high and ends W edges later, counting that first edge. The FIFO word for that lane holds the first bit of the slot in bit W-1 and the last bit in bit 0.
- R2: For each completed slot, the FIFO receives that slot's words in ascending lane index, from lane 0 upward. All of them are written before any word from a later slot.
- R3: A lane whose bit in the lane mask is 0 (bit i controls lane i) writes no word. The words of the enabled lanes follow each other with no gaps in the FIFO. A mask of all zeros writes nothing.
- R4: The lane mask is sampled only on the bit clock edge that carries the frame sync. A mask change in the middle of a slot does not affect that slot.
- R5: A slot whose number of enabled lanes is larger than the free FIFO space (depth minus level) is dropped entirely, and `overrun_o` goes to 1. A slot that exactly fills the FIFO is accepted and does not set the flag.
- R6: `overrun_o` stays at 1 until `ovr_clr_i` is 1 on a clock edge. After that edge it reads 0, unless a new drop happens on the same edge.
- R7: `rd_valid_o` is 1 whenever the FIFO holds a word, and `rd_data_o` shows the oldest word. A word is removed on a clock edge where `rd_valid_o` and `rd_ready_i` are both 1. While `rd_ready_i` is 0, the head word stays in place.
- R8: `level_o` equals the number of words stored in the FIFO. After reset, `level_o` is 0, `rd_valid_o` is 0 and `overrun_o` is 0.
- R9: A frame sync that arrives on the first bit clock edge after a slot ends starts a new slot. Both slots are captured.
- R10: Bit clock edges that come before any frame sync write nothing to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| fsync_i | input | 1 | Frame sync; high for the first bit of a slot |
| sdata_i | input | N | One serial data bit per lane |
| lane_en_i | input | N | Lane enable mask, sampled at frame sync |
| ovr_clr_i | input | 1 | Clears the sticky overrun flag |
| rd_data_o | output | W | Oldest FIFO word |
| rd_valid_o | output | 1 | FIFO holds at least one word |
| rd_ready_i | input | 1 | Consumer accepts the head word |
| level_o | output | $clog2(D+1) | FIFO fill level in words |
| overrun_o | output | 1 | Sticky flag: a slot was dropped |

## Verification
The hardest state to reach from the ports is the boundary of the overrun decision. The FIFO has to hold exactly enough words that the next slot either just fits or misses by one lane. The stimulus gets there with directed slots that use chosen masks: eight lanes, then four, then four more to reach exactly sixteen words, then one more lane to cause a drop. The random bursts also change the mask in the middle of a slot and use back-to-back frames. A bench model that tracks the fill level predicts which slot sets are dropped.

// File: rtl/mlane_rx_pkg.sv
package mlane_rx_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mlane_slot_timer.sv
module mlane_slot_timer #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_i,
  input  logic         fsync_i,
  input  logic [N-1:0] lane_en_i,
  output logic         bit_stb_o,
  output logic         done_o,
  output logic [N-1:0] act_mask_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          bclk_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [N-1:0]  mask_q;

  assign bit_stb_o  = bclk_i & ~bclk_q;
  assign done_o     = done_q;
  assign act_mask_o = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      mask_q <= '0;
    end else begin
      bclk_q <= bclk_i;
      done_q <= 1'b0;
      if (bit_stb_o) begin
        if (fsync_i) begin
          cnt_q  <= CW'(1);
          mask_q <= lane_en_i;
        end else if (cnt_q != '0) begin
          if (cnt_q == CW'(W - 1)) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/mlane_lane_shift.sv
module mlane_lane_shift #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic         sd_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (stb_i) sh_q <= {sh_q[W-2:0], sd_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/mlane_pack_seq.sv
module mlane_pack_seq
  import mlane_rx_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned D  = 16,
  parameter int unsigned LW = $clog2(D + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           done_i,
  input  logic [N-1:0]   mask_i,
  input  logic [N*W-1:0] words_i,
  input  logic [LW-1:0]  level_i,
  input  logic           ovr_clr_i,
  output logic           wr_en_o,
  output logic [W-1:0]   wr_data_o,
  output logic           overrun_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  seq_state_e    st_q;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  hmask_q;
  logic [W-1:0]  hold_q [N];
  logic          ovr_q;
  int unsigned   need;
  logic          drop;

  always_comb begin
    need = 0;
    for (int i = 0; i < N; i++) need += int'(mask_i[i]);
  end

  assign drop = done_i && (need > (D - int'(level_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEQ_IDLE;
      idx_q   <= '0;
      hmask_q <= '0;
      ovr_q   <= 1'b0;
      for (int i = 0; i < N; i++) hold_q[i] <= '0;
    end else begin
      if (drop)           ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;

      if (done_i && !drop) begin
        st_q    <= SEQ_RUN;
        idx_q   <= '0;
        hmask_q <= mask_i;
        for (int i = 0; i < N; i++) hold_q[i] <= words_i[i*W +: W];
      end else if (st_q == SEQ_RUN) begin
        if (idx_q == IW'(N - 1)) st_q <= SEQ_IDLE;
        else                     idx_q <= idx_q + IW'(1);
      end
    end
  end

  assign wr_en_o   = (st_q == SEQ_RUN) && hmask_q[idx_q];
  assign wr_data_o = hold_q[idx_q];
  assign overrun_o = ovr_q;

  // previous set must be fully written before the next one lands
  p_idle_at_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (st_q == SEQ_IDLE));
  p_drop_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> !wr_en_o);
  p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);
endmodule

// File: rtl/mlane_rx_fifo.sv
module mlane_rx_fifo #(
  parameter int unsigned W  = 32,
  parameter int unsigned D  = 16,
  parameter int unsigned LW = $clog2(D + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [LW-1:0] level_o
);
  localparam int unsigned AW = (D > 1) ? $clog2(D) : 1;

  logic [W-1:0]  mem_q [D];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          pop;

  assign pop        = rd_valid_o && rd_ready_i;
  assign rd_valid_o = (cnt_q != '0);
  assign rd_data_o  = mem_q[rp_q];
  assign level_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < D; i++) mem_q[i] <= '0;
    end else begin
      if (wr_en_i) begin
        mem_q[wp_q] <= wr_data_i;
        wp_q <= (wp_q == AW'(D - 1)) ? '0 : wp_q + AW'(1);
      end
      if (pop) rp_q <= (rp_q == AW'(D - 1)) ? '0 : rp_q + AW'(1);
      cnt_q <= cnt_q + LW'(wr_en_i) - LW'(pop);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (cnt_q < LW'(D)));
  p_hold_head_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
endmodule

// File: rtl/mlane_rx_packer.sv
module mlane_rx_packer #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned D  = 16,
  parameter int unsigned LW = $clog2(D + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bclk_i,
  input  logic          fsync_i,
  input  logic [N-1:0]  sdata_i,
  input  logic [N-1:0]  lane_en_i,
  input  logic          ovr_clr_i,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [LW-1:0] level_o,
  output logic          overrun_o
);
  logic           bit_stb, done;
  logic [N-1:0]   act_mask;
  logic [N*W-1:0] lane_words;
  logic           wr_en;
  logic [W-1:0]   wr_data;

  mlane_slot_timer #(.W(W), .N(N)) u_timer (
    .clk_i, .rst_ni, .bclk_i, .fsync_i, .lane_en_i,
    .bit_stb_o (bit_stb),
    .done_o    (done),
    .act_mask_o(act_mask)
  );

  for (genvar l = 0; l < N; l++) begin : g_lane
    mlane_lane_shift #(.W(W)) u_shift (
      .clk_i, .rst_ni,
      .stb_i (bit_stb),
      .sd_i  (sdata_i[l]),
      .word_o(lane_words[l*W +: W])
    );
  end

  mlane_pack_seq #(.W(W), .N(N), .D(D), .LW(LW)) u_seq (
    .clk_i, .rst_ni,
    .done_i   (done),
    .mask_i   (act_mask),
    .words_i  (lane_words),
    .level_i  (level_o),
    .ovr_clr_i,
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data),
    .overrun_o
  );

  mlane_rx_fifo #(.W(W), .D(D), .LW(LW)) u_fifo (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .rd_data_o, .rd_valid_o, .rd_ready_i, .level_o
  );
endmodule

// File: tb/mlane_rx_packer_tb_top.sv
module mlane_rx_packer_tb_top;
  localparam int unsigned W  = 32;
  localparam int unsigned N  = 8;
  localparam int unsigned D  = 16;
  localparam int unsigned LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bclk_i = 1'b0, fsync_i = 1'b0, ovr_clr_i = 1'b0, rd_ready_i = 1'b0;
  logic [N-1:0]  sdata_i = '0, lane_en_i = '0;
  logic [W-1:0]  rd_data_o;
  logic          rd_valid_o, overrun_o;
  logic [LW-1:0] level_o;

  int unsigned errors = 0, checks = 0;
  logic [W-1:0] exp_q[$];
  logic         mdl_ovr = 1'b0;
  logic [W-1:0] fw [N];

  always #4 clk = ~clk;

  mlane_rx_packer #(.W(W), .N(N), .D(D)) dut_i (
    .clk_i(clk), .rst_ni, .bclk_i, .fsync_i, .sdata_i, .lane_en_i, .ovr_clr_i,
    .rd_data_o, .rd_valid_o, .rd_ready_i, .level_o, .overrun_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit fs, input int b);
    @(negedge clk);
    bclk_i = 1'b0; fsync_i = fs;
    for (int l = 0; l < N; l++) sdata_i[l] = (b < 0) ? 1'($urandom) : fw[l][b];
    @(negedge clk);
    @(negedge clk); bclk_i = 1'b1;
    @(negedge clk);
  endtask

  // one slot: mask m at sync, switched to mid half way through
  task automatic send_frame(input logic [N-1:0] m, input logic [N-1:0] mid);
    lane_en_i = m;
    for (int b = W - 1; b >= 0; b--) begin
      if (b == W / 2) lane_en_i = mid;
      send_bit(b == W - 1, b);
    end
    if ($countones(m) > D - exp_q.size()) mdl_ovr = 1'b1;
    else for (int l = 0; l < N; l++) if (m[l]) exp_q.push_back(fw[l]);
  endtask

  task automatic rand_words();
    for (int l = 0; l < N; l++) fw[l] = $urandom;
  endtask

  task automatic settle();
    @(negedge clk); bclk_i = 1'b0; fsync_i = 1'b0;
    repeat (N + 4) @(negedge clk);
  endtask

  task automatic drain(input string req, input bit rnd);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      bit r;
      guard++;
      @(negedge clk);
      chk(level_o == LW'(exp_q.size()), "R8 level", 64'(level_o), 64'(exp_q.size()));
      chk(rd_valid_o == 1'b1, "R7 valid", 64'(rd_valid_o), 64'd1);
      chk(rd_data_o == exp_q[0], req, 64'(rd_data_o), 64'(exp_q[0]));
      r = rnd ? 1'($urandom) : 1'b1;
      rd_ready_i = r;
      @(posedge clk);
      if (r) void'(exp_q.pop_front());
    end
    @(negedge clk);
    rd_ready_i = 1'b0;
    chk(rd_valid_o == 1'b0 && level_o == '0, "R7 empty", 64'(level_o), 64'd0);
  endtask

  task automatic clear_ovr();
    @(negedge clk); ovr_clr_i = 1'b1;
    @(negedge clk); ovr_clr_i = 1'b0;
    mdl_ovr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(level_o == '0 && !rd_valid_o && !overrun_o, "R8 reset",
        {overrun_o, rd_valid_o, 59'(level_o)}, 64'd0);

    // R10: edges with no sync
    lane_en_i = '1;
    for (int i = 0; i < W + 8; i++) send_bit(1'b0, -1);
    settle();
    chk(level_o == '0, "R10 no sync no write", 64'(level_o), 64'd0);

    // R1 R2: all lanes, known patterns
    for (int l = 0; l < N; l++) fw[l] = 32'h8000_0001 | (32'(l) << 8) | (32'hA5 << 20);
    send_frame('1, '1); settle();
    drain("R1 R2 order", 1'b0);

    // R3: sparse and empty masks
    rand_words(); send_frame(8'b1010_0101, 8'b1010_0101); settle();
    drain("R3 skip lanes", 1'b0);
    rand_words(); send_frame('0, '0); settle();
    chk(level_o == '0, "R3 empty mask", 64'(level_o), 64'd0);

    // R4: mid-slot mask change ignored
    rand_words(); send_frame(8'b0000_0110, 8'b1111_1001); settle();
    drain("R4 mask at sync", 1'b0);

    // R9: back to back slots
    rand_words(); send_frame(8'b1100_0011, '0);
    rand_words(); send_frame(8'b0011_1100, '1); settle();
    drain("R9 back to back", 1'b1);

    // R5 boundary: 8 + 4 + 4 fills exactly, then one more lane drops
    rand_words(); send_frame('1, '1);
    rand_words(); send_frame(8'h0F, 8'h0F);
    rand_words(); send_frame(8'hF0, 8'hF0); settle();
    chk(level_o == LW'(D) && !overrun_o, "R5 exact fit",
        {overrun_o, 59'(level_o)}, 64'(D));
    rand_words(); send_frame(8'h01, 8'h01); settle();
    chk(overrun_o == 1'b1 && level_o == LW'(D), "R5 drop set",
        {overrun_o, 59'(level_o)}, {1'b1, 59'(D)});
    repeat (20) @(negedge clk);
    chk(overrun_o == 1'b1, "R6 sticky", 64'(overrun_o), 64'd1);
    clear_ovr();
    chk(overrun_o == 1'b0, "R6 cleared", 64'(overrun_o), 64'd0);
    drain("R5 kept data intact", 1'b1);

    // random bursts
    for (int it = 0; it < 24; it++) begin
      int k = 1 + ($urandom % 3);
      for (int f = 0; f < k; f++) begin
        rand_words();
        send_frame(N'($urandom), N'($urandom));
      end
      settle();
      chk(overrun_o == mdl_ovr, "R5 random overrun", 64'(overrun_o), 64'(mdl_ovr));
      chk(level_o == LW'(exp_q.size()), "R8 random level", 64'(level_o), 64'(exp_q.size()));
      drain("R2 R3 random order", 1'b1);
      clear_ovr();
      chk(overrun_o == 1'b0, "R6 random clear", 64'(overrun_o), 64'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule